// File: doc/BRIEF.md
# Dual-Bus Address Generator

This block holds two independent pointer engines, one for each of two data buses. Each engine owns an address pointer and moves it on command. The arithmetic follows one of four modes. Two modes are linear, with the step added either before or after the address is issued. One mode is a circular buffer bounded by an inclusive low and high index. The last mode adds the step with the carry running from the most significant bit down, which gives the scrambled access order of a radix-2 FFT.

A sequencer drives a mode, a signed step and the ring bounds for each engine. It pulses a per-engine advance strobe whenever the bus needs an address. The issued address appears registered on the clock edge that samples the strobe, together with a one-cycle valid flag. A per-engine load strobe writes the pointer directly.

The mode selection (`unique case` over an enumerated mode) decides the next pointer and which value is issued. The named modes are:

- MD_POST (0): issue the pointer, then add the step.
- MD_PRE (1): add the step, then issue the new pointer.
- MD_RING (2): circular addressing, issued post-modify.
- MD_BREV (3): reversed-carry addressing, issued post-modify.

Each engine has three named transitions per cycle: LOAD, ADVANCE and HOLD.

Top module: `dagen_pair`

## Requirements
- R1: After reset every pointer and every address output is 0, and every valid flag is 0.
- R2: A load strobe writes the load value into that engine's pointer and issues no address: valid is 0 in the following cycle, even if the advance strobe was also high. Load takes priority over advance.
- R3: In a cycle with neither load nor advance, the pointer keeps its value and valid is 0 in the following cycle.
- R4: Mode 0 (MD_POST) behaves as follows. The address output is the pointer before the update. The pointer becomes pointer + step, where the step is AW-bit two's complement and the sum wraps modulo 2^AW.
- R5: Mode 1 (MD_PRE) behaves as follows. The pointer becomes pointer + step, taken modulo 2^AW. The address output is that new value.
- R6: Mode 2 (MD_RING) issues the old pointer. When pointer + step exceeds the high bound, the pointer becomes low + (pointer + step − high − 1). A sum inside [low, high] is taken as is. This holds while the pointer lies inside the ring and |step| does not exceed the ring length.
- R7: Mode 2 with a sum below the low bound sets the pointer to high − (low − (pointer + step) − 1).
- R8: Mode 3 (MD_BREV) issues the old pointer. The new pointer is rev(rev(pointer) + rev(step)), where rev mirrors the AW bits and the sum wraps modulo 2^AW.
- R9: The two engines advance in the same cycle with different modes, and neither affects the other's pointer or address.
- R10: An advance strobe without a load raises valid for exactly the following cycle. The address output keeps its last value while valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | NU*2 | Mode per engine; engine u uses bits [2u+1:2u] |
| step_i | input | NU*AW | Signed step per engine; engine u uses slice [u*AW +: AW] |
| lo_i | input | NU*AW | Ring low bound per engine |
| hi_i | input | NU*AW | Ring high bound per engine |
| ld_i | input | NU | Load strobe per engine |
| ld_val_i | input | NU*AW | Load value per engine |
| adv_i | input | NU | Advance strobe per engine |
| addr_o | output | NU*AW | Issued address per engine, registered |
| vld_o | output | NU | Address valid per engine, high for one cycle |

## Verification
Each engine has exactly one register stage between its inputs and its outputs. An advance or load sampled on one rising edge therefore shows its address and valid just after that edge, and the updated pointer can be seen from the next advance onward. The bench changes inputs and samples outputs 1 ns after each rising edge. It reads a pointer back by issuing a zero-step post-modify advance, so every expected value is compared in the cycle straight after the strobe that produced it. The bench sweeps full step ranges for the linear modes, every pointer and step pair for a small ring, and long reversed-carry sequences.

// File: rtl/dagen_pkg.sv
package dagen_pkg;
    typedef enum logic [1:0] {
        MD_POST = 2'd0,
        MD_PRE  = 2'd1,
        MD_RING = 2'd2,
        MD_BREV = 2'd3
    } dagen_mode_e;
endpackage

// File: rtl/dagen_next.sv
module dagen_next
    import dagen_pkg::*;
#(
    parameter int AW = 8
) (
    input  dagen_mode_e   mode,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] nxt
);
    localparam int SW = AW + 2;

    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    logic signed [SW-1:0] p_s, st_s, lo_s, hi_s, sum_s, ring_s;
    logic [AW-1:0]        brev_sum;

    always_comb begin
        p_s   = signed'({2'b00, ptr});
        st_s  = signed'({{2{step[AW-1]}}, step});
        lo_s  = signed'({2'b00, lo});
        hi_s  = signed'({2'b00, hi});
        sum_s = p_s + st_s;
        if (sum_s > hi_s)
            ring_s = lo_s + (sum_s - hi_s - SW'(1));
        else if (sum_s < lo_s)
            ring_s = hi_s - (lo_s - sum_s - SW'(1));
        else
            ring_s = sum_s;
        brev_sum = mirror(ptr) + mirror(step);
        unique case (mode)
            MD_POST, MD_PRE: nxt = ptr + step;
            MD_RING:         nxt = ring_s[AW-1:0];
            MD_BREV:         nxt = mirror(brev_sum);
            default:         nxt = ptr;
        endcase
    end
endmodule

// File: rtl/dagen_unit.sv
module dagen_unit
    import dagen_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dagen_mode_e   mode,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          vld
);
    typedef enum logic [1:0] { TR_HOLD, TR_LOAD, TR_ADV } tr_e;

    logic [AW-1:0] ptr_q, nxt;
    logic [AW-1:0] issue;
    tr_e           tr;

    dagen_next #(.AW(AW)) u_next (
        .mode(mode), .ptr(ptr_q), .step(step), .lo(lo), .hi(hi), .nxt(nxt)
    );

    always_comb begin
        if (ld)       tr = TR_LOAD;
        else if (adv) tr = TR_ADV;
        else          tr = TR_HOLD;
    end

    always_comb begin
        unique case (mode)
            MD_PRE:  issue = nxt;
            default: issue = ptr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (tr)
                TR_LOAD: ptr_q <= ld_val;
                TR_ADV:  ptr_q <= nxt;
                default: ptr_q <= ptr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= (tr == TR_ADV);
            if (tr == TR_ADV) addr <= issue;
        end
    end

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (!vld && ptr_q == $past(ld_val)));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> ($stable(ptr_q) && !vld && $stable(addr)));
    // R4
    post_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && mode == MD_POST) |=> (vld && addr == $past(ptr_q)));
    // R5
    pre_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && mode == MD_PRE) |=> (vld && addr == ptr_q));
    // R6
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && mode == MD_RING && ptr_q >= lo && ptr_q <= hi)
        |=> (ptr_q >= $past(lo) && ptr_q <= $past(hi)));
endmodule

// File: rtl/dagen_pair.sv
module dagen_pair
    import dagen_pkg::*;
#(
    parameter int AW = 8,
    parameter int NU = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NU*2-1:0]  mode_i,
    input  logic [NU*AW-1:0] step_i,
    input  logic [NU*AW-1:0] lo_i,
    input  logic [NU*AW-1:0] hi_i,
    input  logic [NU-1:0]    ld_i,
    input  logic [NU*AW-1:0] ld_val_i,
    input  logic [NU-1:0]    adv_i,
    output logic [NU*AW-1:0] addr_o,
    output logic [NU-1:0]    vld_o
);
    for (genvar u = 0; u < NU; u++) begin : g_unit
        dagen_unit #(.AW(AW)) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (dagen_mode_e'(mode_i[u*2 +: 2])),
            .step  (step_i[u*AW +: AW]),
            .lo    (lo_i[u*AW +: AW]),
            .hi    (hi_i[u*AW +: AW]),
            .ld    (ld_i[u]),
            .ld_val(ld_val_i[u*AW +: AW]),
            .adv   (adv_i[u]),
            .addr  (addr_o[u*AW +: AW]),
            .vld   (vld_o[u])
        );
    end
endmodule

// File: tb/dagen_pair_tb.sv
module dagen_pair_tb;
    localparam int AW = 8;
    localparam int NU = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NU*2-1:0]  mode_i = '0;
    logic [NU*AW-1:0] step_i = '0, lo_i = '0, hi_i = '0, ld_val_i = '0;
    logic [NU-1:0]    ld_i = '0, adv_i = '0;
    logic [NU*AW-1:0] addr_o;
    logic [NU-1:0]    vld_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dagen_pair #(.AW(AW), .NU(NU)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int rd(input int u);
        return int'(addr_o[u*AW +: AW]);
    endfunction

    task automatic do_load(input int u, input int v);
        ld_i[u] = 1'b1; ld_val_i[u*AW +: AW] = AW'(v);
        cyc();
        ld_i[u] = 1'b0;
    endtask

    task automatic do_adv(input int u, input int md, input int s, output int a);
        mode_i[u*2 +: 2] = 2'(md); step_i[u*AW +: AW] = AW'(s); adv_i[u] = 1'b1;
        cyc();
        adv_i[u] = 1'b0;
        a = rd(u);
    endtask

    task automatic peek(input int u, output int p);
        do_adv(u, 0, 0, p);
    endtask

    function automatic int rev8(input int v);
        int r = 0;
        for (int i = 0; i < AW; i++) if (v[i]) r |= 1 << (AW - 1 - i);
        return r;
    endfunction

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a, p, e, a0, a1;
        cyc(); cyc();
        // R1 reset state
        for (int u = 0; u < NU; u++) begin
            chk(rd(u) == 0, "R1 addr", rd(u), 0);
            chk(vld_o[u] == 1'b0, "R1 vld", vld_o[u], 0);
        end
        rst_n = 1'b1;
        cyc();
        peek(0, p); chk(p == 0, "R1 ptr", p, 0);

        // R2 load beats advance
        adv_i[0] = 1'b1; mode_i[1:0] = 2'd0; step_i[7:0] = 8'd5;
        do_load(0, 77);
        adv_i[0] = 1'b0;
        chk(vld_o[0] == 1'b0, "R2 vld", vld_o[0], 0);
        peek(0, p); chk(p == 77, "R2 ptr", p, 77);

        // R3 hold, R10 valid pulse
        do_adv(0, 0, 3, a);
        chk(vld_o[0] == 1'b1, "R10 vld high", vld_o[0], 1);
        cyc();
        chk(vld_o[0] == 1'b0, "R10 vld low", vld_o[0], 0);
        chk(rd(0) == 77, "R10 addr held", rd(0), 77);
        cyc(); cyc();
        chk(vld_o[0] == 1'b0, "R3 vld", vld_o[0], 0);
        peek(0, p); chk(p == 80, "R3 ptr", p, 80);

        // R4 post-modify sweep
        for (int b = 0; b < 256; b += 37) begin
            for (int s = 0; s < 256; s += 3) begin
                do_load(0, b);
                do_adv(0, 0, s, a);
                chk(a == b, "R4 issue", a, b);
                peek(0, p); e = (b + s) % 256;
                chk(p == e, "R4 ptr", p, e);
            end
        end

        // R5 pre-modify sweep
        for (int b = 5; b < 256; b += 50) begin
            for (int s = 0; s < 256; s += 7) begin
                do_load(0, b);
                do_adv(0, 1, s, a); e = (b + s) % 256;
                chk(a == e, "R5 issue", a, e);
                peek(0, p);
                chk(p == e, "R5 ptr", p, e);
            end
        end

        // R6 / R7 ring: low 10, high 17
        lo_i[7:0] = 8'd10; hi_i[7:0] = 8'd17;
        for (int b = 10; b <= 17; b++) begin
            for (int s = -8; s <= 8; s++) begin
                int off;
                do_load(0, b);
                do_adv(0, 2, s, a);
                chk(a == b, "R6 issue", a, b);
                off = ((b - 10 + s) % 8 + 8) % 8;
                e = 10 + off;
                peek(0, p);
                if (b + s < 10) chk(p == e, "R7 wrap low", p, e);
                else            chk(p == e, "R6 wrap high", p, e);
            end
        end

        // R8 reversed carry
        do_load(0, 0);
        for (int k = 0; k < 256; k++) begin
            do_adv(0, 3, 128, a); e = rev8(k);
            chk(a == e, "R8 unit step", a, e);
        end
        do_load(0, 0);
        for (int k = 0; k < 40; k++) begin
            do_adv(0, 3, 16, a); e = rev8((k * 8) % 256);
            chk(a == e, "R8 coarse step", a, e);
        end

        // R9 both engines in one cycle
        lo_i[15:8] = 8'd100; hi_i[15:8] = 8'd103;
        for (int k = 0; k < 20; k++) begin
            do_load(0, k * 11);
            do_load(1, 100 + (k % 4));
            mode_i = {2'd2, 2'd1}; step_i = {8'd3, 8'(k)}; adv_i = 2'b11;
            cyc();
            adv_i = 2'b00;
            a0 = rd(0); a1 = rd(1);
            e = (k * 11 + k) % 256;
            chk(a0 == e, "R9 engine0", a0, e);
            chk(a1 == 100 + (k % 4), "R9 engine1", a1, 100 + (k % 4));
            peek(1, p); e = 100 + ((k % 4) + 3) % 4;
            chk(p == e, "R9 engine1 ptr", p, e);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule